// File: doc/BRIEF.md
# Channel-Sorting Merge Network

This block takes one event from each of `N_LANES` lanes in the same clock cycle and reorders them so that each output channel receives no more than one event. Each event has a valid bit, a channel number, a sequence number and a payload. The events pass through a pipelined network of compare-exchange nodes wired as an odd-even merge sort, with channel as the sort key. Each node also merges: when two valid events meet on the same channel, the node keeps the newer one by sequence number, marks it as a replacement, and invalidates the other.

A per-channel enable vector sets what happens to a replacement when it leaves the network. If replacement is allowed on that channel, the surviving event is delivered with its flag set. If it is not allowed, the event is dropped, and a one-cycle collision pulse carrying the channel number appears on the same output lane. Sequence numbers are compared modulo `2^SEQ_W`, so a counter that has wrapped still counts as newer. Lane storage, timestamp gating and channel drivers sit outside this block.

Top module: `chan_merge_net`

## Requirements
- R1: A set of events applied on the input in one cycle appears on the output exactly `LAT = log2(N)*(log2(N)+1)/2 + 1` clock edges later (4 for four lanes). A new set may be applied every cycle. No output is valid or pulsing unless an input was valid `LAT` cycles earlier.
- R2: A valid event whose channel no other valid input in the same cycle uses leaves on exactly one output lane. Its channel, sequence number and payload are unchanged, and its replace flag is 0.
- R3: Among the valid output lanes, taken from lane 0 upward, the channel numbers strictly increase. No two valid outputs carry the same channel.
- R4: When two or more valid inputs share a channel, only the one with the newest sequence number survives, with its payload, and its replace flag is 1.
- R5: Sequence A is newer than B when `(A - B) mod 2^SEQ_W` has its top bit clear and is non-zero. For example, with 5-bit numbers, 1 is newer than 31.
- R6: An input lane whose valid bit is 0 never appears on the output. It does not cause a replacement or a collision on the channel it names.
- R7: The enable bit for channel c is `repl_en[c]`. When a replacement survives on channel c and that bit is 0, the event is not delivered, and `coll_pulse` is raised on one lane with `coll_chan` equal to c. When that bit is 1, the event is delivered and no pulse is raised.
- R8: A collision pulse lasts one cycle. It is low in the next cycle unless a new collision follows.
- R9: While `rst_n` is low and in the first cycle after it rises, all `out_valid` and `coll_pulse` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N_LANES | Per-lane event valid |
| in_chan | input | N_LANES*CHAN_W | Per-lane channel number, lane i at bits [i*CHAN_W +: CHAN_W] |
| in_seq | input | N_LANES*SEQ_W | Per-lane sequence number |
| in_data | input | N_LANES*DATA_W | Per-lane payload |
| repl_en | input | 2**CHAN_W | Replacement allowed per channel, bit c for channel c |
| out_valid | output | N_LANES | Delivered event valid per output lane |
| out_replace | output | N_LANES | Delivered event displaced another event |
| out_chan | output | N_LANES*CHAN_W | Delivered channel per lane |
| out_seq | output | N_LANES*SEQ_W | Delivered sequence number per lane |
| out_data | output | N_LANES*DATA_W | Delivered payload per lane |
| coll_pulse | output | N_LANES | One-cycle collision indication per lane |
| coll_chan | output | N_LANES*CHAN_W | Channel of the collision on that lane |

## Verification
The bench sweeps every valid mask together with every channel assignment of four lanes over four channels. The sequence numbers it uses cross the wrap point, and the enable vector changes from set to set. A node that compared sequence numbers without wrap would keep the older event whenever the numbers straddle zero. A network that merged only adjacent lanes would let three events on one channel leave as two. If invalid lanes sorted among valid channels, they would produce false replacements. A collision stage that ignored the enable bit would deliver events it should drop, or drop events it should deliver. The bench also checks the cycle before and the cycle after each expected output, so a wrong pipeline depth or a pulse that stays high is reported.

// File: rtl/chan_merge_pkg.sv
// Package: chan_merge_pkg
// Constant functions that lay out the odd-even merge sort schedule.
// Assumes the lane count is a power of two and at least two.
package chan_merge_pkg;

    // Ceiling log2 of a positive integer.
    function automatic int clog2_i(input int n);
        int r;
        r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    // Number of compare-exchange stages for n lanes.
    function automatic int sort_stages(input int n);
        int lg;
        lg = clog2_i(n);
        return (lg * (lg + 1)) / 2;
    endfunction

    // Merge block span (p) used by stage s.
    function automatic int stage_span(input int n, input int s);
        int cnt;
        cnt = 0;
        for (int p = 1; p < n; p = p * 2) begin
            for (int k = p; k >= 1; k = k / 2) begin
                if (cnt == s) return p;
                cnt++;
            end
        end
        return 1;
    endfunction

    // Compare distance (k) used by stage s.
    function automatic int stage_step(input int n, input int s);
        int cnt;
        cnt = 0;
        for (int p = 1; p < n; p = p * 2) begin
            for (int k = p; k >= 1; k = k / 2) begin
                if (cnt == s) return k;
                cnt++;
            end
        end
        return 1;
    endfunction

    // True when lane x is the lower member of a pair (x, x+k) in the stage.
    function automatic bit pair_low(input int n, input int p, input int k, input int x);
        for (int j = k % p; j < n - k; j = j + 2 * k) begin
            for (int i = 0; i < k; i++) begin
                if ((i + j == x) && (i + j + k < n) &&
                    ((i + j) / (2 * p) == (i + j + k) / (2 * p)))
                    return 1'b1;
            end
        end
        return 1'b0;
    endfunction

endpackage

// File: rtl/cmn_cx_node.sv
// Module: cmn_cx_node
// Compare-exchange element that also merges. The output on lo_o has the
// smaller key {~valid, channel}, so invalid events sort above every real
// channel. When both inputs are valid on the same channel, the newer one
// (modular sequence compare) goes to lo_o with its replace flag set and
// hi_o is invalidated. Purely combinational. Event word layout:
// {valid, replace, chan, seq, data}.
module cmn_cx_node #(
    parameter int CHAN_W = 3,
    parameter int SEQ_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic [CHAN_W+SEQ_W+DATA_W+1:0] lo_i,
    input  logic [CHAN_W+SEQ_W+DATA_W+1:0] hi_i,
    output logic [CHAN_W+SEQ_W+DATA_W+1:0] lo_o,
    output logic [CHAN_W+SEQ_W+DATA_W+1:0] hi_o
);
    localparam int S_LO  = DATA_W;
    localparam int C_LO  = DATA_W + SEQ_W;
    localparam int R_BIT = DATA_W + SEQ_W + CHAN_W;
    localparam int V_BIT = R_BIT + 1;

    logic              lo_v, hi_v;
    logic [CHAN_W-1:0] lo_c, hi_c;
    logic [SEQ_W-1:0]  lo_s, hi_s, seq_diff;
    logic [CHAN_W:0]   lo_key, hi_key;
    logic              same_chan, hi_newer;

    // Field extraction and the modular newer test.
    always_comb begin
        lo_v      = lo_i[V_BIT];
        hi_v      = hi_i[V_BIT];
        lo_c      = lo_i[C_LO +: CHAN_W];
        hi_c      = hi_i[C_LO +: CHAN_W];
        lo_s      = lo_i[S_LO +: SEQ_W];
        hi_s      = hi_i[S_LO +: SEQ_W];
        seq_diff  = hi_s - lo_s;
        hi_newer  = !seq_diff[SEQ_W-1] && (seq_diff != '0);
        lo_key    = {!lo_v, lo_c};
        hi_key    = {!hi_v, hi_c};
        same_chan = lo_v && hi_v && (lo_c == hi_c);
    end

    // Merge on a channel match, otherwise order by key.
    always_comb begin
        if (same_chan) begin
            lo_o         = hi_newer ? hi_i : lo_i;
            lo_o[R_BIT]  = 1'b1;
            hi_o         = hi_newer ? lo_i : hi_i;
            hi_o[V_BIT]  = 1'b0;
            hi_o[R_BIT]  = 1'b0;
        end else if (lo_key > hi_key) begin
            lo_o = hi_i;
            hi_o = lo_i;
        end else begin
            lo_o = lo_i;
            hi_o = hi_i;
        end
    end
endmodule

// File: rtl/cmn_stage.sv
// Module: cmn_stage
// One registered column of the sort network. The schedule functions pick
// which lanes pair at distance K_STEP inside merge blocks of span P_SPAN.
// Unpaired lanes pass straight through. Assumes the caller supplies a
// valid (P_SPAN, K_STEP) from chan_merge_pkg.
module cmn_stage
    import chan_merge_pkg::*;
#(
    parameter int N_LANES = 4,
    parameter int CHAN_W  = 3,
    parameter int SEQ_W   = 6,
    parameter int DATA_W  = 8,
    parameter int P_SPAN  = 1,
    parameter int K_STEP  = 1
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [N_LANES-1:0][CHAN_W+SEQ_W+DATA_W+1:0] ev_i,
    output logic [N_LANES-1:0][CHAN_W+SEQ_W+DATA_W+1:0] ev_q
);
    localparam int EW    = CHAN_W + SEQ_W + DATA_W + 2;
    localparam int V_BIT = EW - 1;

    logic [N_LANES-1:0][EW-1:0] ev_nxt;
    logic [N_LANES-1:0]         vin, vout;

    for (genvar x = 0; x < N_LANES; x++) begin : g_lane
        if (pair_low(N_LANES, P_SPAN, K_STEP, x)) begin : g_node
            cmn_cx_node #(
                .CHAN_W(CHAN_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W)
            ) u_node (
                .lo_i(ev_i[x]),
                .hi_i(ev_i[x+K_STEP]),
                .lo_o(ev_nxt[x]),
                .hi_o(ev_nxt[x+K_STEP])
            );
        end else if (!((x >= K_STEP) && pair_low(N_LANES, P_SPAN, K_STEP, x - K_STEP))) begin : g_pass
            assign ev_nxt[x] = ev_i[x];
        end
        assign vin[x]  = ev_i[x][V_BIT];
        assign vout[x] = ev_q[x][V_BIT];
    end

    // Stage register; valid bits travel with the event word.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_nxt;
    end

    // Merging can only remove events, never create them.
    p_no_gain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vout) <= $past($countones(vin)));
endmodule

// File: rtl/cmn_collide.sv
// Module: cmn_collide
// Final registered stage. Applies the per-channel replacement policy to
// the sorted events. A replacement on a channel whose enable bit is clear
// is withheld and reported as a one-cycle collision on the same lane.
// Assumes each channel appears at most once in ev_i.
module cmn_collide #(
    parameter int N_LANES = 4,
    parameter int CHAN_W  = 3,
    parameter int SEQ_W   = 6,
    parameter int DATA_W  = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [N_LANES-1:0][CHAN_W+SEQ_W+DATA_W+1:0] ev_i,
    input  logic [(1<<CHAN_W)-1:0]                      repl_en,
    output logic [N_LANES-1:0]                          out_valid,
    output logic [N_LANES-1:0]                          out_replace,
    output logic [N_LANES*CHAN_W-1:0]                   out_chan,
    output logic [N_LANES*SEQ_W-1:0]                    out_seq,
    output logic [N_LANES*DATA_W-1:0]                   out_data,
    output logic [N_LANES-1:0]                          coll_pulse,
    output logic [N_LANES*CHAN_W-1:0]                   coll_chan
);
    localparam int S_LO  = DATA_W;
    localparam int C_LO  = DATA_W + SEQ_W;
    localparam int R_BIT = DATA_W + SEQ_W + CHAN_W;
    localparam int V_BIT = R_BIT + 1;

    for (genvar x = 0; x < N_LANES; x++) begin : g_lane
        logic              ev_v, ev_r, blocked;
        logic [CHAN_W-1:0] ev_c;

        // Decide whether this lane's event is delivered or withheld.
        always_comb begin
            ev_v    = ev_i[x][V_BIT];
            ev_r    = ev_i[x][R_BIT];
            ev_c    = ev_i[x][C_LO +: CHAN_W];
            blocked = ev_v && ev_r && !repl_en[ev_c];
        end

        // Output register for the delivered event and the collision pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid[x]                <= 1'b0;
                out_replace[x]              <= 1'b0;
                out_chan[x*CHAN_W +: CHAN_W] <= '0;
                out_seq[x*SEQ_W +: SEQ_W]    <= '0;
                out_data[x*DATA_W +: DATA_W] <= '0;
                coll_pulse[x]               <= 1'b0;
                coll_chan[x*CHAN_W +: CHAN_W] <= '0;
            end else begin
                out_valid[x]                <= ev_v && !blocked;
                out_replace[x]              <= ev_v && ev_r;
                out_chan[x*CHAN_W +: CHAN_W] <= ev_c;
                out_seq[x*SEQ_W +: SEQ_W]    <= ev_i[x][S_LO +: SEQ_W];
                out_data[x*DATA_W +: DATA_W] <= ev_i[x][DATA_W-1:0];
                coll_pulse[x]               <= blocked;
                coll_chan[x*CHAN_W +: CHAN_W] <= ev_c;
            end
        end

        // A withheld event never also leaves as a delivery.
        p_coll_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
            coll_pulse[x] |-> !out_valid[x]);

        // A collision only ever names a channel whose enable was clear.
        p_coll_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
            coll_pulse[x] |-> !(($past(repl_en) >> coll_chan[x*CHAN_W +: CHAN_W]) & 1'b1));
    end
endmodule

// File: rtl/chan_merge_net.sv
// Module: chan_merge_net
// Top of the channel-sorting merge network. Packs the lane inputs into
// event words, runs them through log2(N)*(log2(N)+1)/2 registered merge-sort
// stages and then the registered collision stage. Latency is fixed at
// stages + 1 cycles, with one new set accepted per cycle. Assumes N_LANES
// is a power of two, at least 2.
module chan_merge_net
    import chan_merge_pkg::*;
#(
    parameter int N_LANES = 4,
    parameter int CHAN_W  = 3,
    parameter int SEQ_W   = 6,
    parameter int DATA_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_LANES-1:0]          in_valid,
    input  logic [N_LANES*CHAN_W-1:0]   in_chan,
    input  logic [N_LANES*SEQ_W-1:0]    in_seq,
    input  logic [N_LANES*DATA_W-1:0]   in_data,
    input  logic [(1<<CHAN_W)-1:0]      repl_en,
    output logic [N_LANES-1:0]          out_valid,
    output logic [N_LANES-1:0]          out_replace,
    output logic [N_LANES*CHAN_W-1:0]   out_chan,
    output logic [N_LANES*SEQ_W-1:0]    out_seq,
    output logic [N_LANES*DATA_W-1:0]   out_data,
    output logic [N_LANES-1:0]          coll_pulse,
    output logic [N_LANES*CHAN_W-1:0]   coll_chan
);
    localparam int EW   = CHAN_W + SEQ_W + DATA_W + 2;
    localparam int NSTG = sort_stages(N_LANES);
    localparam int LAT  = NSTG + 1;

    logic [NSTG:0][N_LANES-1:0][EW-1:0] pipe;

    // Pack lane inputs into event words with a clear replace flag.
    for (genvar x = 0; x < N_LANES; x++) begin : g_pack
        assign pipe[0][x] = {in_valid[x], 1'b0,
                             in_chan[x*CHAN_W +: CHAN_W],
                             in_seq[x*SEQ_W +: SEQ_W],
                             in_data[x*DATA_W +: DATA_W]};
    end

    // Chain of registered compare-exchange columns.
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        cmn_stage #(
            .N_LANES(N_LANES), .CHAN_W(CHAN_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W),
            .P_SPAN(stage_span(N_LANES, s)), .K_STEP(stage_step(N_LANES, s))
        ) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .ev_i (pipe[s]),
            .ev_q (pipe[s+1])
        );
    end

    cmn_collide #(
        .N_LANES(N_LANES), .CHAN_W(CHAN_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W)
    ) u_collide (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (pipe[NSTG]),
        .repl_en    (repl_en),
        .out_valid  (out_valid),
        .out_replace(out_replace),
        .out_chan   (out_chan),
        .out_seq    (out_seq),
        .out_data   (out_data),
        .coll_pulse (coll_pulse),
        .coll_chan  (coll_chan)
    );

    // History of input activity, used to check the fixed latency.
    logic [LAT-1:0] act_hist;
    always_ff @(posedge clk) begin
        if (!rst_n) act_hist <= '0;
        else        act_hist <= {act_hist[LAT-2:0], |in_valid};
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid || |coll_pulse) |-> act_hist[LAT-1]);

    // Valid outputs are strictly ascending by channel, hence unique.
    for (genvar a = 0; a < N_LANES; a++) begin : g_ord_a
        for (genvar b = a + 1; b < N_LANES; b++) begin : g_ord_b
            p_sorted_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid[a] && out_valid[b]) |->
                (out_chan[a*CHAN_W +: CHAN_W] < out_chan[b*CHAN_W +: CHAN_W]));
        end
    end
endmodule

// File: tb/chan_merge_net_bench.sv
// Bench: sweeps every valid mask and channel assignment of 4 lanes over
// 4 channels and checks the outputs against an arithmetic reference model.
module chan_merge_net_bench;
    localparam int NL  = 4;
    localparam int CW  = 2;
    localparam int SW  = 5;
    localparam int DW  = 8;
    localparam int NCH = 1 << CW;
    localparam int LAT = 4;   // 2*3/2 sort columns + 1 policy stage

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NL-1:0]     in_valid;
    logic [NL*CW-1:0]  in_chan;
    logic [NL*SW-1:0]  in_seq;
    logic [NL*DW-1:0]  in_data;
    logic [NCH-1:0]    repl_en;
    logic [NL-1:0]     out_valid, out_replace, coll_pulse;
    logic [NL*CW-1:0]  out_chan, coll_chan;
    logic [NL*SW-1:0]  out_seq;
    logic [NL*DW-1:0]  out_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    chan_merge_net #(.N_LANES(NL), .CHAN_W(CW), .SEQ_W(SW), .DATA_W(DW)) u_chan_merge_net (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_seq(in_seq), .in_data(in_data), .repl_en(repl_en),
        .out_valid(out_valid), .out_replace(out_replace), .out_chan(out_chan),
        .out_seq(out_seq), .out_data(out_data), .coll_pulse(coll_pulse),
        .coll_chan(coll_chan)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Stimulus for one set; rank[i] larger means newer sequence.
    int          s_v[NL], s_c[NL], s_rank[NL];
    logic [SW-1:0] s_seq[NL];
    logic [DW-1:0] s_dat[NL];
    logic [NCH-1:0] s_en;

    task automatic check_idle(input string req);
        chk(out_valid == '0, req, int'(out_valid), 0);
        chk(coll_pulse == '0, req, int'(coll_pulse), 0);
    endtask

    task automatic check_result();
        int prev_ch;
        // R3: valid outputs strictly ascending in channel.
        prev_ch = -1;
        for (int x = 0; x < NL; x++) begin
            if (out_valid[x]) begin
                chk(int'(out_chan[x*CW +: CW]) > prev_ch, "R3", int'(out_chan[x*CW +: CW]), prev_ch + 1);
                prev_ch = int'(out_chan[x*CW +: CW]);
            end
        end
        for (int c = 0; c < NCH; c++) begin
            int cnt, best, got, gl, ncol;
            bit expect_out, expect_col;
            cnt = 0; best = -1;
            for (int i = 0; i < NL; i++) begin
                if (s_v[i] != 0 && s_c[i] == c) begin
                    cnt++;
                    if (best < 0 || s_rank[i] > s_rank[best]) best = i;
                end
            end
            expect_out = (cnt == 1) || (cnt > 1 && s_en[c]);
            expect_col = (cnt > 1) && !s_en[c];
            got = 0; gl = 0; ncol = 0;
            for (int x = 0; x < NL; x++) begin
                if (out_valid[x] && int'(out_chan[x*CW +: CW]) == c) begin got++; gl = x; end
                if (coll_pulse[x] && int'(coll_chan[x*CW +: CW]) == c) ncol++;
            end
            // R6/R7: delivery count per channel (invalid lanes never count).
            chk(got == int'(expect_out), (cnt > 1) ? "R7" : "R6", got, int'(expect_out));
            chk(ncol == int'(expect_col), "R7", ncol, int'(expect_col));
            if (got == 1 && expect_out) begin
                if (cnt == 1) begin
                    chk(out_replace[gl] == 1'b0, "R2", int'(out_replace[gl]), 0);
                    chk(out_seq[gl*SW +: SW] == s_seq[best], "R2", int'(out_seq[gl*SW +: SW]), int'(s_seq[best]));
                    chk(out_data[gl*DW +: DW] == s_dat[best], "R2", int'(out_data[gl*DW +: DW]), int'(s_dat[best]));
                end else begin
                    chk(out_replace[gl] == 1'b1, "R4", int'(out_replace[gl]), 1);
                    chk(out_seq[gl*SW +: SW] == s_seq[best], "R4 R5", int'(out_seq[gl*SW +: SW]), int'(s_seq[best]));
                    chk(out_data[gl*DW +: DW] == s_dat[best], "R4", int'(out_data[gl*DW +: DW]), int'(s_dat[best]));
                end
            end
        end
    endtask

    // Apply a set for one cycle, then check before, at and after LAT.
    task automatic run_set();
        @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            in_valid[i]           = (s_v[i] != 0);
            in_chan[i*CW +: CW]   = CW'(s_c[i]);
            in_seq[i*SW +: SW]    = s_seq[i];
            in_data[i*DW +: DW]   = s_dat[i];
        end
        repl_en = s_en;
        @(negedge clk);
        in_valid = '0;
        repeat (LAT - 2) @(negedge clk);
        check_idle("R1");            // one cycle early: nothing yet
        @(negedge clk);
        check_result();
        @(negedge clk);
        check_idle("R8");            // pulses and outputs gone a cycle later
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = '1;
        in_chan  = '0;
        in_seq   = '0;
        in_data  = '0;
        repl_en  = '0;
        repeat (3) @(negedge clk);
        check_idle("R9");
        in_valid = '0;
        rst_n    = 1'b1;
        @(negedge clk);
        check_idle("R9");

        // R5 directed: 1 is newer than 31 on a shared channel.
        for (int i = 0; i < NL; i++) begin
            s_v[i] = 0; s_c[i] = 0; s_rank[i] = 0; s_seq[i] = '0; s_dat[i] = '0;
        end
        s_v[0] = 1; s_c[0] = 2; s_seq[0] = 5'd31; s_dat[0] = 8'hA5; s_rank[0] = 0;
        s_v[3] = 1; s_c[3] = 2; s_seq[3] = 5'd1;  s_dat[3] = 8'h3C; s_rank[3] = 1;
        s_en = 4'b0100;
        run_set();

        // R2-R8 sweep: every valid mask and channel assignment.
        for (int idx = 0; idx < 4096; idx++) begin
            int base;
            base = (idx * 3) % 32;
            for (int i = 0; i < NL; i++) begin
                s_v[i]    = (idx >> i) & 1;
                s_c[i]    = (idx >> (4 + 2 * i)) & 3;
                s_rank[i] = ((i + idx) % 4) * 3;
                s_seq[i]  = SW'((base + s_rank[i]) % 32);
                s_dat[i]  = DW'((idx * 4 + i) % 256);
            end
            s_en = NCH'((idx * 5 + idx / 16) % 16);
            run_set();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(10 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule